// File: doc/BRIEF.md
# Binary Shape Upsampling Interpolator

This block rebuilds a full-resolution binary shape block from a down-converted one. For every low-resolution sample position it produces four interpolated binary pixels. A window source, normally a delay line, presents twelve reference pixels. Four of them are inner pixels, named A, B, C and D. Eight of them are outer pixels, named E to L. Each interpolated pixel is found by forming a weighted count of the reference pixels and comparing it with a threshold. The threshold is looked up in a loadable table, and the pattern of the outer pixels selects the entry.

A single decision datapath serves all four outputs and produces one pixel per cycle. Two rotating registers hand it a different role assignment on each cycle. A 4-entry ring moves the heavy weight from A through D. An 8-entry ring steps by two positions and reorders E to L for the table index. The first output of a window is decided straight from the window inputs. The remaining three outputs come from the rings. The block raises an advance strobe to the window source during the cycle in which it decides the last pixel. If the window stays valid, the next position therefore begins with no idle cycle, at one position every four cycles.

Top module: `upsmp_interp`

## Requirements
- R1: During and right after reset, pix_valid, pix_out, pix_idx and win_adv are all 0.
- R2: A window is accepted on a clock edge at which win_valid is 1 and the block is idle. The four results appear on the next four cycles with pix_valid high and pix_idx equal to 0, 1, 2 and 3 in turn.
- R3: Result k (k = 0..3) is 1 exactly when S exceeds the selected threshold, and 0 otherwise. S = 4·inner[k] + 2·(the other three inner bits) + (number of ones in win_outer). Bits 0 to 3 of win_inner are A to D.
- R4: Result k reads the threshold table at an 8-bit index whose bit i equals win_outer bit ((i + 2k) mod 8).
- R5: A cycle with tbl_we high stores tbl_wdata at tbl_addr. Every later decision that uses that index sees the new value.
- R6: win_adv is high for exactly one cycle per window. That cycle is the one in which result 2 is on the outputs, so win_adv rises together with pix_idx = 2.
- R7: While the block is deciding results 1 to 3 of a window, changes on win_inner, win_outer and win_valid have no effect on those results.
- R8: With win_valid held high and the source advancing on win_adv, consecutive windows produce results on every cycle with no gap. pix_idx wraps from 3 to 0.
- R9: The comparison is strict. S equal to the threshold gives 0, and S one above the threshold gives 1.
- R10: When idle with win_valid low, pix_valid and win_adv stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| win_valid | input | 1 | Window pixels are valid |
| win_inner | input | 4 | Inner pixels, bit 0 = A ... bit 3 = D |
| win_outer | input | 8 | Outer pixels E..L, bit 0 = E |
| tbl_we | input | 1 | Threshold table write enable |
| tbl_addr | input | 8 | Threshold table write index |
| tbl_wdata | input | 5 | Threshold value to write |
| pix_out | output | 1 | Interpolated pixel |
| pix_valid | output | 1 | pix_out holds a fresh result |
| pix_idx | output | 2 | Which of the four results is on pix_out |
| win_adv | output | 1 | Window source may shift on the next edge |

## Verification
The bench sets a threshold exactly at the weighted count, and then one below it. A design that compares with greater-or-equal, or that weights the inner pixels wrongly, flips those pixels. A design that rotates the outer ring by the wrong step, or in the wrong direction, reads a different table entry on results 1 to 3, and the position-dependent table then exposes it. Window inputs are scrambled while the results of a window are being decided. A design that keeps reading the live inputs instead of its rings shows corrupted results. A streaming run holds win_valid high across three windows. A design that raises win_adv one cycle late, or that inserts an idle cycle, loses the gap-free pix_idx order or repeats a window.

// File: rtl/upsmp_pkg.sv
// Shared types for the binary upsampling interpolator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package upsmp_pkg;
    // Engine state: idle waits for a window; run walks results 1..3
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } upsmp_state_e;
endpackage

// File: rtl/upsmp_ring.sv
// Rotating register of N bits. On load it stores the load value already
// rotated by STEP. On shift it rotates its own content by STEP. The bit at
// index 0 after a rotation came from index STEP.
// Assumes STEP < N. Reset clears the ring to all zeros.
module upsmp_ring #(
    parameter int N    = 4,
    parameter int STEP = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [N-1:0] load_val,
    output logic [N-1:0] ring
);
    logic [N-1:0] src;
    logic [N-1:0] rot;

    // Pick the vector that gets rotated
    assign src = load ? load_val : ring;

    // Rotation wiring: rot[i] takes src[(i+STEP) mod N]
    for (genvar i = 0; i < N; i++) begin : g_rot
        assign rot[i] = src[(i + STEP) % N];
    end

    // Hold or update the ring
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring <= '0;
        end else if (load || shift) begin
            ring <= rot;
        end
    end
endmodule

// File: rtl/upsmp_thresh_table.sv
// Threshold store with a synchronous write port and an asynchronous read
// port. The contents are not reset, so they must be written before use.
module upsmp_thresh_table #(
    parameter int IDX_W = 8,
    parameter int TH_W  = 5
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [TH_W-1:0]  wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [TH_W-1:0]  rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TH_W-1:0] mem [DEPTH];

    // Store one threshold per write strobe
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational lookup for the decision stage
    assign rdata = mem[raddr];
endmodule

// File: rtl/upsmp_decide.sv
// Weighted count and threshold compare for one interpolated pixel.
// inner[0] carries weight 4, the other inner bits weight 2, and each outer
// bit weight 1. The result is 1 when the count is strictly above th.
// Assumes SUM_W >= 3.
module upsmp_decide #(
    parameter int INNER_N = 4,
    parameter int OUTER_N = 8,
    parameter int TH_W    = 5,
    parameter int SUM_W   = 5
) (
    input  logic [INNER_N-1:0] inner,
    input  logic [OUTER_N-1:0] outer,
    input  logic [TH_W-1:0]    th,
    output logic               hit
);
    localparam int CMP_W = (SUM_W > TH_W) ? SUM_W : TH_W;

    logic [SUM_W-1:0] acc;

    // Accumulate the weighted pixel count
    always_comb begin
        acc = {{(SUM_W-3){1'b0}}, inner[0], 2'b00};
        for (int i = 1; i < INNER_N; i++) begin
            acc = acc + {{(SUM_W-2){1'b0}}, inner[i], 1'b0};
        end
        for (int j = 0; j < OUTER_N; j++) begin
            acc = acc + {{(SUM_W-1){1'b0}}, outer[j]};
        end
    end

    // Strict compare against the selected threshold
    assign hit = CMP_W'(acc) > CMP_W'(th);
endmodule

// File: rtl/upsmp_interp.sv
// Binary shape upsampling interpolator top. It accepts a 12-pixel window
// when idle and emits four interpolated pixels on four consecutive cycles
// through one shared decision datapath. Result 0 is decided from the
// window inputs. Results 1..3 are decided from two rotating rings loaded
// at acceptance. win_adv is raised while the last result is decided, so
// the source shifts on the edge that registers it.
// Assumes the threshold table is written before the first window.
module upsmp_interp
    import upsmp_pkg::*;
#(
    parameter int INNER_N    = 4,
    parameter int OUTER_N    = 8,
    parameter int OUTER_STEP = 2,
    parameter int TH_W       = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       win_valid,
    input  logic [INNER_N-1:0]         win_inner,
    input  logic [OUTER_N-1:0]         win_outer,
    input  logic                       tbl_we,
    input  logic [OUTER_N-1:0]         tbl_addr,
    input  logic [TH_W-1:0]            tbl_wdata,
    output logic                       pix_out,
    output logic                       pix_valid,
    output logic [$clog2(INNER_N)-1:0] pix_idx,
    output logic                       win_adv
);
    localparam int PH_W    = $clog2(INNER_N);
    localparam int MAX_SUM = 4 + 2 * (INNER_N - 1) + OUTER_N;
    localparam int SUM_W   = $clog2(MAX_SUM + 1);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(INNER_N - 1);

    upsmp_state_e     state;
    logic [PH_W-1:0]  phase;
    logic             start;
    logic             running;
    logic             fire;
    logic [INNER_N-1:0] inner_ring;
    logic [OUTER_N-1:0] outer_ring;
    logic [INNER_N-1:0] sel_inner;
    logic [OUTER_N-1:0] sel_outer;
    logic [TH_W-1:0]  th_val;
    logic             decision;

    // Handshake and operand source selection
    assign running   = (state == ST_RUN);
    assign start     = (state == ST_IDLE) && win_valid;
    assign fire      = start || running;
    assign sel_inner = running ? inner_ring : win_inner;
    assign sel_outer = running ? outer_ring : win_outer;
    assign win_adv   = running && (phase == LAST_PH);

    upsmp_ring #(.N(INNER_N), .STEP(1)) u_inner_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .shift    (running),
        .load_val (win_inner),
        .ring     (inner_ring)
    );

    upsmp_ring #(.N(OUTER_N), .STEP(OUTER_STEP)) u_outer_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .shift    (running),
        .load_val (win_outer),
        .ring     (outer_ring)
    );

    upsmp_thresh_table #(.IDX_W(OUTER_N), .TH_W(TH_W)) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .raddr (sel_outer),
        .rdata (th_val)
    );

    upsmp_decide #(
        .INNER_N (INNER_N),
        .OUTER_N (OUTER_N),
        .TH_W    (TH_W),
        .SUM_W   (SUM_W)
    ) u_decide (
        .inner (sel_inner),
        .outer (sel_outer),
        .th    (th_val),
        .hit   (decision)
    );

    // Sequence the results within one window position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= '0;
        end else if (start) begin
            state <= ST_RUN;
            phase <= PH_W'(1);
        end else if (running) begin
            phase <= phase + 1'b1;
            if (phase == LAST_PH) begin
                state <= ST_IDLE;
            end
        end
    end

    // Register each decided pixel with its index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out   <= 1'b0;
            pix_valid <= 1'b0;
            pix_idx   <= '0;
        end else begin
            pix_valid <= fire;
            if (fire) begin
                pix_out <= decision;
                pix_idx <= running ? phase : '0;
            end
        end
    end
endmodule

// File: rtl/upsmp_interp_chk.sv
// Protocol checker for upsmp_interp. It watches the result index order and
// the timing of the advance strobe. It is attached to every instance of
// upsmp_interp by the bind statement at the end of this file.
module upsmp_interp_chk #(
    parameter int INNER_N = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       win_valid,
    input logic                       pix_valid,
    input logic [$clog2(INNER_N)-1:0] pix_idx,
    input logic                       win_adv
);
    localparam int IW = $clog2(INNER_N);
    localparam logic [IW-1:0] LAST = IW'(INNER_N - 1);

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_idx != LAST) |=> (pix_valid && pix_idx == IW'($past(pix_idx) + 1'b1))); // R2
    AST_FIRST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_idx == '0) |-> $past(win_valid)); // R2
    AST_ADV_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        win_adv |-> (pix_valid && pix_idx == IW'(INNER_N - 2))); // R6
    AST_ADV_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        win_adv |=> (pix_valid && pix_idx == LAST && !win_adv)); // R6
endmodule

bind upsmp_interp upsmp_interp_chk #(.INNER_N(INNER_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .pix_valid (pix_valid),
    .pix_idx   (pix_idx),
    .win_adv   (win_adv)
);

// File: tb/sim_upsmp_interp.sv
// Directed bench for upsmp_interp: one task per scenario.
module sim_upsmp_interp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_valid = 1'b0;
    logic [3:0] win_inner = '0;
    logic [7:0] win_outer = '0;
    logic       tbl_we = 1'b0;
    logic [7:0] tbl_addr = '0;
    logic [4:0] tbl_wdata = '0;
    logic       pix_out;
    logic       pix_valid;
    logic [1:0] pix_idx;
    logic       win_adv;

    int checks = 0;
    int errors = 0;
    int tb_th [256];

    always #2 clk = ~clk;

    upsmp_interp u0 (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid),
        .win_inner(win_inner), .win_outer(win_outer),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .pix_out(pix_out), .pix_valid(pix_valid), .pix_idx(pix_idx),
        .win_adv(win_adv)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // Expected pixel from R3/R4
    function automatic int model_bit(input logic [3:0] in_v, input logic [7:0] out_v, input int k);
        logic [7:0] cf;
        int s;
        for (int i = 0; i < 8; i++) cf[i] = out_v[(i + 2 * k) % 8];
        s = 4 * int'(in_v[k]) + 2 * ($countones(in_v) - int'(in_v[k])) + $countones(out_v);
        return (s > tb_th[cf]) ? 1 : 0;
    endfunction

    task automatic wr_th(input int a, input int v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 8'(a); tbl_wdata = 5'(v);
        tb_th[a] = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic fill_table();
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            tbl_we = 1'b1; tbl_addr = 8'(a); tbl_wdata = 5'((a * 5 + 7) % 19);
            tb_th[a] = (a * 5 + 7) % 19;
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pix_valid", int'(pix_valid), 0);
        check("R1 pix_out", int'(pix_out), 0);
        check("R1 pix_idx", int'(pix_idx), 0);
        check("R1 win_adv", int'(win_adv), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        win_valid = 1'b0;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            check("R10 idle pix_valid", int'(pix_valid), 0);
            check("R10 idle win_adv", int'(win_adv), 0);
        end
    endtask

    // One window. With scramble set, the inputs change once it is accepted (R7).
    task automatic t_window(input logic [3:0] in_v, input logic [7:0] out_v, input bit scramble, input string req);
        @(negedge clk);
        win_valid = 1'b1; win_inner = in_v; win_outer = out_v;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 0) begin
                win_valid = 1'b0;
                if (scramble) begin
                    win_inner = ~in_v; win_outer = ~out_v; win_valid = 1'b1;
                end
            end
            check({req, " R2 valid"}, int'(pix_valid), 1);
            check({req, " R2 idx"}, int'(pix_idx), k);
            check({req, " R3 R4 pixel"}, int'(pix_out), model_bit(in_v, out_v, k));
            check({req, " R6 adv"}, int'(win_adv), (k == 2) ? 1 : 0);
            if (k == 2) win_valid = 1'b0;
        end
        @(negedge clk);
        check({req, " R2 done"}, int'(pix_valid), 0);
    endtask

    // Three windows with win_valid held high (R8)
    task automatic t_stream();
        logic [3:0] ins  [3];
        logic [7:0] outs [3];
        ins[0] = 4'b1010; outs[0] = 8'b1100_1010;
        ins[1] = 4'b0111; outs[1] = 8'b0001_1101;
        ins[2] = 4'b1001; outs[2] = 8'b1111_0000;
        @(negedge clk);
        win_valid = 1'b1; win_inner = ins[0]; win_outer = outs[0];
        for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            check("R8 stream valid", int'(pix_valid), 1);
            check("R8 stream idx", int'(pix_idx), n % 4);
            check("R8 stream pixel", int'(pix_out), model_bit(ins[n / 4], outs[n / 4], n % 4));
            if (win_adv && (n / 4) < 2) begin
                win_inner = ins[n / 4 + 1]; win_outer = outs[n / 4 + 1];
            end
            if (n == 11) win_valid = 1'b0;
        end
        @(negedge clk);
        check("R8 stream end", int'(pix_valid), 0);
    endtask

    // Strict compare boundary using index 0 (R5, R9)
    task automatic t_boundary();
        // inner=A only, outer=0: result 0 count is 4, and every index is 0
        wr_th(0, 4);
        t_window(4'b0001, 8'h00, 1'b0, "R9 equal");
        wr_th(0, 3);
        t_window(4'b0001, 8'h00, 1'b0, "R5 R9 above");
        // all ones: count 18, every index is 255
        wr_th(255, 18);
        t_window(4'b1111, 8'hFF, 1'b0, "R9 max equal");
        wr_th(255, 17);
        t_window(4'b1111, 8'hFF, 1'b0, "R9 max above");
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        fill_table();
        t_idle();
        t_window(4'b0010, 8'b1011_0001, 1'b0, "R3 pattern a");
        t_window(4'b1100, 8'b0110_1001, 1'b0, "R4 pattern b");
        t_window(4'b0101, 8'b0000_0111, 1'b1, "R7 scramble");
        t_stream();
        t_boundary();
        t_idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule